// File: doc/BRIEF.md
# Address Line Alias Tester

This engine looks for broken memory address lines. When one line is open or stuck, two addresses that differ only in that bit land on the same storage word. To find this, the engine takes a test address and flips one address bit at a time to get a partner address. For each partner inside the region it reads the partner, writes the complement of that value to the test address, and reads the partner again. If the partner now shows the value just written, the two addresses alias and the flipped bit points to the faulty line.

The engine makes two passes over the region. The first uses the lowest word of the region as the test address, so a single one walks through zeros. The second uses the second-to-last word of the region as the test address, so a single zero walks through ones. A fault does not stop the walk. Every mask is checked, and the first failing combination is kept for diagnosis.

The engine is the master of a word-addressed synchronous memory with a one-cycle read latency. Software or a boot sequencer pulses `start` with the region base and the region size in words, then waits for `done`.

Top module: `addr_line_walker`

## Requirements
- R1: In each pass the flip mask starts at address bit 0 and moves up one bit per step through bit AW-1, then the pass ends.
- R2: A partner address below the base, or at or above base+size, is skipped. The engine never reads or writes any address outside the region.
- R3: For each partner in range, the order is fixed. First a read of the partner. Two cycles later, a write of the bitwise complement of the returned word to the test address. Then a second read of the partner. Read data is valid the cycle after `mem_re`.
- R4: A fault is flagged when the second partner read returns exactly the word written to the test address.
- R5: The first pass uses test address `base`. The second pass uses `base+size-2`. No write goes to any other address.
- R6: A fault does not shorten the walk. The number of reads is twice the number of in-range partners over both passes, whether or not a fault is present.
- R7: `fail_taddr`, `fail_partner` and `fail_mask` keep the first fault in walk order. Pass one comes first, then lower masks. `fail` stays high until the next start.
- R8: `done` is high for exactly one cycle after both passes. `busy` is high from the cycle after `start` until that cycle. A `start` pulse while busy is ignored.
- R9: After reset, `busy`, `done`, `fail`, `mem_re` and `mem_we` are low.
- R10: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a test when idle |
| base | input | AW | First word address of the region |
| size | input | AW+1 | Region length in words (at least 2, base+size at most 2^AW) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | At least one aliasing fault was seen |
| fail_taddr | output | AW | Test address of the first fault |
| fail_partner | output | AW | Partner address of the first fault |
| fail_mask | output | AW | One-hot flip mask of the first fault |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_re` |

## Verification
Two things can happen in the same step of the walk: a fault being recorded, and the walk moving on to the next mask or to the next pass. When the stuck bit is the top address bit, the fault lands on the last mask of a pass. That means the record and the pass switch or `done` happen together. The bench provokes this with a memory model that forces one address bit to zero. It then checks that the recorded first fault, the read count and the single `done` pulse all match the values the bench predicts by walking the masks itself. Regions whose top partners fall outside the range exercise the other overlap, where a skip and a pass switch happen together.

// File: rtl/addr_line_walker.sv
module addr_line_walker #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_taddr,
  output logic [AW-1:0] fail_partner,
  output logic [AW-1:0] fail_mask,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD1, S_CAP, S_WR, S_RD2, S_CMP, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] base_q, taddr, mask;
  logic [AW:0]   end_q;
  logic          pass;
  logic [DW-1:0] comp;

  wire [AW-1:0] partner = taddr ^ mask;
  wire          in_rng  = ({1'b0, partner} >= {1'b0, base_q}) && ({1'b0, partner} < end_q);
  wire          adv     = (st == S_CHK && !in_rng) || st == S_CMP;
  wire          hit     = st == S_CMP && mem_rdata == comp;
  wire [AW:0]   last_t  = end_q - (AW+1)'(2);

  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign mem_re    = st == S_RD1 || st == S_RD2;
  assign mem_we    = st == S_WR;
  assign mem_addr  = mem_we ? taddr : partner;
  assign mem_wdata = comp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      base_q       <= '0;
      end_q        <= '0;
      taddr        <= '0;
      mask         <= '0;
      pass         <= 1'b0;
      comp         <= '0;
      fail         <= 1'b0;
      fail_taddr   <= '0;
      fail_partner <= '0;
      fail_mask    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q       <= base;
          end_q        <= {1'b0, base} + size;
          taddr        <= base;
          mask         <= AW'(1);
          pass         <= 1'b0;
          fail         <= 1'b0;
          fail_taddr   <= '0;
          fail_partner <= '0;
          fail_mask    <= '0;
          st           <= S_CHK;
        end
        S_CHK:  if (in_rng) st <= S_RD1;
        S_RD1:  st <= S_CAP;
        S_CAP:  begin comp <= ~mem_rdata; st <= S_WR; end
        S_WR:   st <= S_RD2;
        S_RD2:  st <= S_CMP;
        S_DONE: st <= S_IDLE;
        default: ;
      endcase
      if (hit) begin
        fail <= 1'b1;
        if (!fail) begin
          fail_taddr   <= taddr;
          fail_partner <= partner;
          fail_mask    <= mask;
        end
      end
      if (adv) begin
        if (mask[AW-1]) begin
          if (!pass) begin
            pass  <= 1'b1;
            taddr <= last_t[AW-1:0];
            mask  <= AW'(1);
            st    <= S_CHK;
          end else st <= S_DONE;
        end else begin
          mask <= mask << 1;
          st   <= S_CHK;
        end
      end
    end
  end

  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we));
  a_r3_write_complement: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == ~$past(mem_rdata));
  a_r3_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re, 2));
  a_r3_reread_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_re);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r2_read_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ({1'b0, mem_addr} >= {1'b0, base_q}) && ({1'b0, mem_addr} < end_q));
  a_r7_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && st != S_IDLE) |=> fail);
  a_r1_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(fail_mask));

endmodule

// File: tb/tb_addr_line_walker.sv
module tb_addr_line_walker;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW:0]   size = '0;
  logic          busy, done, fail, mem_re, mem_we;
  logic [AW-1:0] fail_taddr, fail_partner, fail_mask, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  addr_line_walker #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .size(size),
    .busy(busy), .done(done), .fail(fail), .fail_taddr(fail_taddr),
    .fail_partner(fail_partner), .fail_mask(fail_mask), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [DW-1:0] mem [NW];
  int stuck = -1;
  int cur_b = 0, cur_s = 2;
  int n_checks = 0, n_fails = 0;
  int m_checks = 0, m_fails = 0;
  int reads = 0;

  function automatic int phys(input int a);
    return (stuck >= 0) ? (a & ~(1 << stuck)) : a;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      m_checks++;
      if (!(int'(mem_addr) == cur_b || int'(mem_addr) == cur_b + cur_s - 2)) begin
        m_fails++;
        $display("FAIL R5 write addr actual %0d expected %0d or %0d", mem_addr, cur_b, cur_b + cur_s - 2);
      end
      m_checks++;
      if (mem_wdata !== ~mem_rdata) begin
        m_fails++;
        $display("FAIL R3 write data actual %h expected %h", mem_wdata, ~mem_rdata);
      end
      mem[phys(int'(mem_addr))] <= mem_wdata;
    end
    if (mem_re) begin
      reads++;
      m_checks++;
      if (int'(mem_addr) < cur_b || int'(mem_addr) >= cur_b + cur_s) begin
        m_fails++;
        $display("FAIL R2 read addr actual %0d expected in [%0d,%0d)", mem_addr, cur_b, cur_b + cur_s);
      end
      mem_rdata <= mem[phys(int'(mem_addr))];
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void predict(input int b, input int s, input int k,
                                  output bit ef, output int et, output int ep,
                                  output int em, output int nr);
    ef = 0; et = 0; ep = 0; em = 0; nr = 0;
    for (int ps = 0; ps < 2; ps++) begin
      int t;
      t = ps == 0 ? b : b + s - 2;
      for (int j = 0; j < AW; j++) begin
        int p;
        p = t ^ (1 << j);
        if (p >= b && p < b + s) begin
          nr += 2;
          if (j == k && !ef) begin
            ef = 1; et = t; ep = p; em = 1 << j;
          end
        end
      end
    end
  endfunction

  task automatic run(input int b, input int s, input int k, input bit poke);
    bit ef; int et, ep, em, nr, r0, cyc;
    bit seen;
    predict(b, s, k, ef, et, ep, em, nr);
    for (int i = 0; i < NW; i++) mem[i] = $urandom;
    stuck = k; cur_b = b; cur_s = s;
    @(negedge clk);
    base = AW'(b); size = (AW+1)'(s); start = 1'b1;
    r0 = reads;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      base = '0; size = (AW+1)'(NW); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 0; cyc = 0;
    while (!seen && cyc < 5000) begin
      if (done) seen = 1; else begin @(negedge clk); cyc++; end
    end
    check(seen, "R8 done seen", seen, 1);
    check(fail === ef, "R4 fail flag", fail, ef);
    check(reads - r0 == nr, "R6 R1 read count", reads - r0, nr);
    if (ef) begin
      check(int'(fail_taddr) == et, "R7 first taddr", fail_taddr, et);
      check(int'(fail_partner) == ep, "R7 first partner", fail_partner, ep);
      check(int'(fail_mask) == em, "R7 first mask", fail_mask, em);
    end
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", done, 0);
    check(busy === 1'b0, "R8 idle after done", busy, 0);
    check(fail === ef, "R7 fail held", fail, ef);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + m_checks, n_fails + m_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && fail === 0, "R9 reset outputs", {busy, done, fail}, 0);
    check(mem_re === 0 && mem_we === 0, "R9 reset strobes", {mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, NW, -1, 0);
    run(0, NW, 0, 0);
    run(0, NW, AW-1, 0);
    run(2, 14, 0, 0);
    run(512, 512, AW-1, 0);
    run(100, 2, 1, 0);
    run(37, 300, 3, 1);
    for (int n = 0; n < 25; n++) begin
      int b, s, k;
      b = $urandom_range(0, NW - 2);
      s = $urandom_range(2, NW - b);
      k = $urandom_range(0, AW);
      if (k == AW) k = -1;
      run(b, s, k, n % 5 == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + m_checks, n_fails + m_fails);
    $finish;
  end
endmodule